// File: doc/BRIEF.md
# SPI Byte Master with Coded Rate Divider

This block shifts one byte at a time out of a serial peripheral interface master port while shifting a byte in from the selected slave. A 3-bit rate code picks how fast the serial clock runs relative to a peripheral clock. The peripheral clock is half the core clock. The rate set is not monotonic: the all-ones code gives the fastest rate, the full peripheral clock. Clock polarity and clock phase select one of the four usual SPI modes. A separate enable input gates the whole engine, and the serial clock line is held high whenever the engine is disabled, whatever the polarity.

A byte enters through a valid/ready handshake. The port accepts a byte only in a cycle where both `tx_valid` and `tx_ready` are high. `tx_ready` is high only while the engine is enabled and no transfer is running. The port has no queue. A `tx_valid` pulse that arrives while `tx_ready` is low is dropped and does nothing. If the sender holds `tx_valid` high instead, the byte is accepted at the first cycle in which `tx_ready` returns high. The received byte appears on `rx_data`. `done` marks that a complete byte has been exchanged.

Top module: `spi_byte_master`

## Requirements
- R1: With H equal to 2^(code+1) core cycles for rate codes 0 to 6 and H equal to 1 core cycle for code 7, consecutive SCK edges within a transfer are H core cycles apart. The SCK period is therefore the peripheral clock (core/2) divided by 2, 4, 8, 16, 32, 64, 128 or 1.
- R2: While no transfer runs, `sck` equals `cpol` if `enable` is 1. It is 1 whenever `enable` is 0, even when `cpol` is 0.
- R3: Data moves MSB first on `mosi` and `miso`. With `cpha`=0, the first bit is on `mosi` before the first SCK edge. Odd-numbered edges (1st, 3rd, and so on) capture `miso`, and even-numbered edges change `mosi`. With `cpha`=1, odd-numbered edges change `mosi` and even-numbered edges capture `miso`.
- R4: Take A as the accepting clock edge. `ss_n` goes low right after A. The first SCK edge comes 2H cycles after A. A transfer has exactly 16 SCK edges. `ss_n` returns high 18H cycles after A, which is H cycles after the last edge, with `sck` already back at its idle level.
- R5: `tx_ready` is 1 only when `enable` is 1 and no transfer runs. A `tx_valid` pulse while `tx_ready` is 0 starts nothing and does not change the byte being sent.
- R6: After a transfer, `rx_data` holds the 8 bits captured from `miso`, with the first captured bit in bit 7.
- R7: `done` rises in the same cycle that `ss_n` returns high after a complete transfer. It stays 1 until the next accepted byte and is 0 in the cycle after that acceptance.
- R8: Dropping `enable` during a transfer ends it at the next clock edge. `ss_n` goes to 1 and `done` stays 0.
- R9: After reset, `ss_n`=1, `done`=0, `rx_data`=0 and `mosi`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the peripheral clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Engine enable; 0 forces SCK high and aborts a transfer |
| cpol | input | 1 | SCK idle level while enabled |
| cpha | input | 1 | Sampling phase select |
| rate_code | input | 3 | Coded SCK divider select |
| tx_valid | input | 1 | Byte offered for sending |
| tx_ready | output | 1 | Engine can accept a byte |
| tx_data | input | 8 | Byte to send |
| rx_data | output | 8 | Last byte received |
| done | output | 1 | Byte exchange complete |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The bench builds the block with its default parameters: an 8-bit byte and a 3-bit rate code. With these values it can drive every code, including the divide-by-one setting, where SCK toggles on every core cycle, and the slowest divider, which gives a half period of 128 core cycles. A bench-side slave model follows the SCK edges in all four polarity and phase combinations. It measures the gaps between edges and compares the bytes exchanged in both directions.

// File: rtl/spi_pkg.sv
package spi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_XFER = 2'd2,
    ST_TAIL = 2'd3
  } spi_state_e;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] code,
  output logic              tick
);
  localparam int NCODES   = 1 << RATE_W;
  localparam int HALF_MAX = 2 << (NCODES - 2);
  localparam int CNT_W    = $clog2(HALF_MAX);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  // all-ones code: one core cycle per half period, otherwise 2^(code+1)
  always_comb begin
    if (&code) limit = '0;
    else       limit = CNT_W'((32'd2 << code) - 32'd1);
  end

  assign tick = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == limit) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  // R1: half-period counter never passes the coded limit
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= limit));
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         load_cpha,
  input  logic         shift_en,
  input  logic         capture_en,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_data
);
  logic [W-1:0] tx_sr;
  logic [W-1:0] rx_sr;
  logic         mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr  <= '0;
      rx_sr  <= '0;
      mosi_q <= 1'b0;
    end else begin
      if (load) begin
        if (load_cpha) begin
          tx_sr  <= load_data;
          mosi_q <= 1'b0;
        end else begin
          tx_sr  <= {load_data[W-2:0], 1'b0};
          mosi_q <= load_data[W-1];
        end
      end else if (shift_en) begin
        mosi_q <= tx_sr[W-1];
        tx_sr  <= {tx_sr[W-2:0], 1'b0};
      end
      if (capture_en) rx_sr <= {rx_sr[W-2:0], miso};
    end
  end

  assign mosi    = mosi_q;
  assign rx_data = rx_sr;

  // R3: the data line only moves on a load or a shift edge
  a_r3_mosi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift_en) |=> $stable(mosi_q));
  // R3: never shift and capture on the same edge
  a_r3_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_en && capture_en));
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl #(
  parameter int W      = 8,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              tx_valid,
  input  logic              tick,
  output logic              tx_ready,
  output logic              accept,
  output logic              run,
  output logic [RATE_W-1:0] cfg_code,
  output logic              sck_q,
  output logic              ss_n,
  output logic              done,
  output logic              shift_en,
  output logic              capture_en
);
  import spi_pkg::*;

  localparam int NEDGE = 2 * W;
  localparam int EW    = $clog2(NEDGE + 1);

  spi_state_e    state;
  logic [EW-1:0] edge_cnt;
  logic          cfg_cpha;
  logic          cfg_cpol;
  logic          leading;
  logic          edge_now;

  assign tx_ready   = enable && (state == ST_IDLE);
  assign accept     = tx_valid && tx_ready;
  assign run        = (state != ST_IDLE);
  assign leading    = ~edge_cnt[0];
  assign edge_now   = (state == ST_XFER) && tick;
  assign shift_en   = edge_now && (cfg_cpha ? leading : ~leading);
  assign capture_en = edge_now && (cfg_cpha ? ~leading : leading);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      edge_cnt <= '0;
      cfg_code <= '0;
      cfg_cpha <= 1'b0;
      cfg_cpol <= 1'b0;
      sck_q    <= 1'b1;
      ss_n     <= 1'b1;
      done     <= 1'b0;
    end else if (!enable) begin
      state    <= ST_IDLE;
      edge_cnt <= '0;
      sck_q    <= cpol;
      ss_n     <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          sck_q <= cpol;
          if (accept) begin
            state    <= ST_LEAD;
            ss_n     <= 1'b0;
            done     <= 1'b0;
            edge_cnt <= '0;
            cfg_code <= rate_code;
            cfg_cpha <= cpha;
            cfg_cpol <= cpol;
          end
        end
        ST_LEAD: if (tick) state <= ST_XFER;
        ST_XFER: if (tick) begin
          sck_q    <= ~sck_q;
          edge_cnt <= edge_cnt + 1'b1;
          if (edge_cnt == EW'(NEDGE - 1)) state <= ST_TAIL;
        end
        ST_TAIL: if (tick) begin
          state <= ST_IDLE;
          ss_n  <= 1'b1;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: a disable always returns the engine to idle
  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (state == ST_IDLE));
  // R4: clock is back at idle level before select releases
  a_r4_idle_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TAIL) |-> (sck_q == cfg_cpol));
  // R1: clock only moves on a divider tick
  a_r1_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_XFER) && !tick && enable) |=> $stable(sck_q));
  // R4: never more than 16 edges
  a_r4_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt <= EW'(NEDGE));
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int DATA_W = 8,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] rx_data,
  output logic              done,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n
);
  logic              accept;
  logic              run;
  logic              tick;
  logic [RATE_W-1:0] cfg_code;
  logic              sck_q;
  logic              shift_en;
  logic              capture_en;

  spi_ctrl #(.W(DATA_W), .RATE_W(RATE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cpol(cpol), .cpha(cpha),
    .rate_code(rate_code), .tx_valid(tx_valid), .tick(tick),
    .tx_ready(tx_ready), .accept(accept), .run(run), .cfg_code(cfg_code),
    .sck_q(sck_q), .ss_n(ss_n), .done(done),
    .shift_en(shift_en), .capture_en(capture_en)
  );

  spi_rate_gen #(.RATE_W(RATE_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(run), .code(cfg_code), .tick(tick)
  );

  spi_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_data(tx_data),
    .load_cpha(cpha), .shift_en(shift_en), .capture_en(capture_en),
    .miso(miso), .mosi(mosi), .rx_data(rx_data)
  );

  // disabled engine parks the clock line high
  assign sck = enable ? sck_q : 1'b1;

  // R5: no new byte offered while a slave is selected
  a_r5_no_ready_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_n |-> !tx_ready);
  // R7: completion coincides with select release
  a_r7_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $rose(ss_n));
endmodule

// File: tb/spi_byte_master_bench.sv
module spi_byte_master_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic [2:0] rate_code = 3'd0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = 8'd0;
  logic [7:0] rx_data;
  logic       done;
  logic       sck;
  logic       mosi;
  logic       miso = 1'b0;
  logic       ss_n;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_byte_master u_spi_byte_master (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cpol(cpol), .cpha(cpha),
    .rate_code(rate_code), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_data(rx_data), .done(done), .sck(sck),
    .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  // {cpol, cpha, rate_code, byte sent, byte the slave returns}
  localparam logic [20:0] VEC [8] = '{
    {1'b0, 1'b0, 3'd7, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 3'd0, 8'h81, 8'h7E},
    {1'b1, 1'b0, 3'd1, 8'h5A, 8'hC3},
    {1'b1, 1'b1, 3'd2, 8'hFF, 8'h00},
    {1'b0, 1'b0, 3'd3, 8'h01, 8'h80},
    {1'b1, 1'b1, 3'd4, 8'h96, 8'h69},
    {1'b0, 1'b1, 3'd5, 8'h00, 8'hFF},
    {1'b1, 1'b0, 3'd6, 8'hC7, 8'h2B}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int half_of(input logic [2:0] c);
    return (c == 3'd7) ? 1 : (2 << c);
  endfunction

  task automatic xfer(input logic p, input logic ph, input logic [2:0] c,
                      input logic [7:0] tx, input logic [7:0] sl, input bit inject);
    int h, cyc, edges, last, mi;
    bit gaps_ok;
    logic prev;
    logic [7:0] got;
    h = half_of(c);
    @(negedge clk);
    enable = 1'b1; cpol = p; cpha = ph; rate_code = c;
    @(negedge clk); @(negedge clk);
    check(sck == p, "R2 idle sck", sck, p);
    tx_valid = 1'b1; tx_data = tx;
    @(negedge clk);
    tx_valid = 1'b0;
    check(ss_n == 1'b0, "R4 select after accept", ss_n, 0);
    check(done == 1'b0, "R7 done cleared by accept", done, 0);
    if (!ph) begin miso = sl[7]; mi = 1; end else mi = 0;
    prev = sck; edges = 0; cyc = 0; last = 0; gaps_ok = 1'b1; got = '0;
    while (ss_n == 1'b0 && cyc < 6000) begin
      @(negedge clk);
      cyc++;
      if (inject && cyc == 5) begin
        check(tx_ready == 1'b0, "R5 not ready while busy", tx_ready, 0);
        tx_valid = 1'b1; tx_data = ~tx;
      end else if (inject && cyc == 6) tx_valid = 1'b0;
      if (sck != prev) begin
        edges++;
        if ((cyc - last) != ((edges == 1) ? 2*h : h)) gaps_ok = 1'b0;
        last = cyc;
        prev = sck;
        if ((edges % 2 == 1) != ph) got = {got[6:0], mosi};
        else if (mi < 8) begin miso = sl[7-mi]; mi++; end
      end
    end
    check(gaps_ok, "R1 edge spacing", gaps_ok, 1);
    check(edges == 16, "R4 edge count", edges, 16);
    check(cyc == 18*h, "R4 select length", cyc, 18*h);
    check(cyc - last == h, "R4 tail gap", cyc - last, h);
    check(sck == p, "R4 idle sck at release", sck, p);
    check(done == 1'b1, "R7 done at release", done, 1);
    check(got == tx, "R3 bits on mosi", got, tx);
    check(rx_data == sl, "R6 received byte", rx_data, sl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(ss_n == 1'b1, "R9 ss_n reset", ss_n, 1);
    check(done == 1'b0, "R9 done reset", done, 0);
    check(rx_data == 8'h00, "R9 rx reset", rx_data, 0);
    check(mosi == 1'b0, "R9 mosi reset", mosi, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 disabled clock forced high even with cpol 0; R5 not ready
    check(sck == 1'b1, "R2 disabled sck high", sck, 1);
    check(tx_ready == 1'b0, "R5 disabled not ready", tx_ready, 0);
    tx_valid = 1'b1; tx_data = 8'h33;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(ss_n == 1'b1, "R5 disabled write ignored", ss_n, 1);

    for (int i = 0; i < 8; i++)
      xfer(VEC[i][20], VEC[i][19], VEC[i][18:16], VEC[i][15:8], VEC[i][7:0], 1'b0);

    // R5 busy write dropped, original byte still sent
    xfer(1'b0, 1'b0, 3'd0, 8'h6B, 8'hD2, 1'b1);
    repeat (20) @(negedge clk);
    check(ss_n == 1'b1, "R5 no second transfer", ss_n, 1);
    check(done == 1'b1, "R7 done holds", done, 1);

    // R8 abort by disable
    tx_valid = 1'b1; tx_data = 8'hE1; rate_code = 3'd2;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (30) @(negedge clk);
    check(ss_n == 1'b0, "R8 transfer running", ss_n, 0);
    enable = 1'b0;
    @(negedge clk);
    check(ss_n == 1'b1, "R8 select released", ss_n, 1);
    check(done == 1'b0, "R8 no done", done, 0);
    check(sck == 1'b1, "R2 sck high after abort", sck, 1);
    repeat (300) @(negedge clk);
    check(done == 1'b0, "R8 done stays low", done, 0);

    // R7 done clears on next accept after an aborted run
    xfer(1'b1, 1'b1, 3'd7, 8'h3E, 8'hB9, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule